// File: doc/BRIEF.md
# Receive Character Buffer with Sticky Overrun Flag

This block sits behind a serial receiver's deserializer. Each completed character arrives as a one-cycle valid strobe with an 8-bit data byte. The block stores it in a 64-entry first-in first-out buffer that a bus master drains through a small register port. The port also exposes a 16-bit status word and reports the current fill count on its own output.

When a character completes while the buffer already holds 64 bytes, a sticky overrun flag is raised. The stored bytes are left untouched and the new byte is thrown away. From then on every incoming character is refused, even after the master has freed space. The flag clears only through a two-step handshake: the master first reads the status word and sees the flag at 1, then writes 0 to bit 0. Turning the receiver off leaves the flag as it is. A manual reset input clears the flag without touching the buffer.

Top module: `rxq_top`

## Requirements
- R1: After reset, `fill_count` is 0, a status read returns 16'h0000, and a data read returns 16'h0000.
- R2: A character strobed in with `rx_en`=1 and the flag clear is stored. Data reads (`reg_sel`=0, `rd_en`=1) return the stored bytes in arrival order in bits 7:0, with bits 15:8 at 0. Each read removes one byte, and `fill_count` tracks the number of stored bytes from 0 to 64.
- R3: A data read while the buffer is empty returns 0 and removes nothing, so later bytes still come out in order.
- R4: A character that completes while 64 bytes are stored, with no data read in the same cycle, sets the overrun flag (status bit 0). The stored bytes are unchanged and the new byte is dropped.
- R5: While the flag is 1, no character is stored, even after data reads have freed space.
- R6: The status word (`reg_sel`=1) carries the flag in bit 0, and bits 15:1 always read 0. Writing ones to bits 15:1 has no effect.
- R7: A status read that returns the flag at 1 arms a clear. The next status write clears the flag only if it has bit 0 = 0 and the clear is armed. Any status write disarms the clear. Writing 1, or writing 0 without an armed read, leaves the flag set.
- R8: With `rx_en`=0, incoming strobes are ignored and the flag keeps its value.
- R9: A character arriving in the same cycle as a data read on a full buffer is stored after the read takes its byte. No overrun is flagged and the count stays at 64.
- R10: Raising `soft_rst` for one cycle clears the flag and the armed state, and leaves the stored bytes and `fill_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst | input | 1 | Synchronous manual reset: clears the flag only |
| rx_en | input | 1 | Receiver enable |
| rx_valid | input | 1 | One-cycle strobe: a character has completed |
| rx_data | input | 8 | Received character |
| reg_sel | input | 1 | 0 = data register, 1 = status register |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register, combinational |
| fill_count | output | 7 | Number of stored bytes, 0 to 64 |

## Verification
The bench fills the buffer exactly to 64 and then strobes a character in the same cycle as a read. A design that checked fullness before taking the read would raise a false overrun there, or lose the byte. It drives the clear handshake out of order: it writes 1, and it writes 0 with no armed read. A design that accepted either would drop the flag early. After space has been freed with the flag set, it sends a character and checks the count and the drain order. This catches a design that resumes reception on its own. It also reads the empty buffer in the middle of a stream, and checks that a manual reset keeps the stored bytes and their order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W  = 8;
    localparam int REG_W   = 16;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
        logic     wbit0;
    } bus_req_t;

    function automatic logic [REG_W-1:0] status_word(input logic ovr);
        return {{(REG_W-1){1'b0}}, ovr};
    endfunction

    function automatic logic [REG_W-1:0] data_word(input logic [CHAR_W-1:0] b,
                                                   input logic             valid);
        return valid ? {{(REG_W-CHAR_W){1'b0}}, b} : '0;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_req_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CW-1:0]    count_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q;
    logic             pop_take, push_take;

    assign empty_o   = (count_q == '0);
    assign full_o    = (count_q == CW'(DEPTH));
    assign pop_take  = pop_req_i && !empty_o;
    assign push_take = push_req_i && (!full_o || pop_take);
    assign head_o    = mem[rd_ptr];
    assign count_o   = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_take) wr_ptr <= wr_ptr + 1'b1;
            if (pop_take)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_take, pop_take})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_take) mem[wr_ptr] <= data_i;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH)); // R2

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop_req_i && empty_o) |=> (rd_ptr == $past(rd_ptr))); // R3

    AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        (full_o && !pop_req_i) |=> (count_q == CW'(DEPTH))); // R4

endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic stat_wr_i,
    input  logic wbit0_i,
    output logic flag_o
);

    logic flag_q, armed_q, clear_ok;

    assign clear_ok = stat_wr_i && !wbit0_i && armed_q;
    assign flag_o   = flag_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_i)         flag_q <= 1'b1;
            else if (clear_ok) flag_q <= 1'b0;

            if (stat_wr_i)                armed_q <= 1'b0;
            else if (stat_rd_i && flag_q) armed_q <= 1'b1;
        end
    end

    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $fell(flag_q) |-> ($past(armed_q) || $past(soft_rst))); // R7

    AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst || soft_rst)
        $rose(armed_q) |-> $past(flag_q)); // R7

endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          rx_en,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          reg_sel,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic [CW-1:0] fill_count
);
    import rxq_pkg::*;

    bus_req_t             req;
    logic                 ovr_flag, accept, ovr_event, pop_req;
    logic                 empty, full;
    logic [CHAR_W-1:0]    head;
    logic                 unused_wr_hi;

    assign req.rd    = rd_en;
    assign req.wr    = wr_en;
    assign req.sel   = reg_sel_e'(reg_sel);
    assign req.wbit0 = wr_data[0];
    assign unused_wr_hi = ^wr_data[15:1];

    assign pop_req   = req.rd && (req.sel == SEL_DATA);
    assign accept    = rx_valid && rx_en && !ovr_flag;
    assign ovr_event = accept && full && !pop_req;

    rxq_store #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_req_i (accept),
        .data_i     (rx_data),
        .pop_req_i  (pop_req),
        .head_o     (head),
        .empty_o    (empty),
        .full_o     (full),
        .count_o    (fill_count)
    );

    rxq_ovr_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .set_i     (ovr_event),
        .stat_rd_i (req.rd && (req.sel == SEL_STAT)),
        .stat_wr_i (req.wr && (req.sel == SEL_STAT)),
        .wbit0_i   (req.wbit0),
        .flag_o    (ovr_flag)
    );

    always_comb begin
        if (req.sel == SEL_STAT) rd_data = status_word(ovr_flag);
        else                     rd_data = data_word(head, !empty);
    end

    AST_BLOCKED_WHILE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !(pop_req && !empty)) |=> (fill_count == $past(fill_count))); // R5

    AST_RX_OFF_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !soft_rst && !(wr_en && reg_sel)) |=> (ovr_flag == $past(ovr_flag))); // R8

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_sel |-> (rd_data[15:1] == '0)); // R6

endmodule

// File: tb/rxq_top_test.sv
module rxq_top_test;

    logic        clk = 1'b0;
    logic        rst, soft_rst, rx_en, rx_valid, reg_sel, rd_en, wr_en;
    logic [7:0]  rx_data;
    logic [15:0] wr_data, rd_data;
    logic [6:0]  fill_count;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];
    bit m_flag = 0;

    always #2.5 clk = ~clk;

    rxq_top uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .rx_en(rx_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .reg_sel(reg_sel),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fill_count(fill_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each data read against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rd_en && !reg_sel) begin
                logic [15:0] e;
                e = (exp_q.size() > 0) ? {8'h00, exp_q.pop_front()} : 16'h0000;
                check(rd_data == e, "R2/R3 data read", rd_data, e);
            end
        end
    end

    task automatic rx_char(input logic [7:0] b, input logic en);
        @(negedge clk);
        rx_en = en; rx_valid = 1'b1; rx_data = b;
        if (en && !m_flag) begin
            if (exp_q.size() < 64) exp_q.push_back(b);
            else m_flag = 1;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_en = 1'b1;
    endtask

    task automatic rd_fifo();
        @(negedge clk);
        reg_sel = 1'b0; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_status(input logic [15:0] e, input string tag);
        @(negedge clk);
        reg_sel = 1'b1; rd_en = 1'b1;
        #1 check(rd_data == e, tag, rd_data, e);
        @(posedge clk); #1;
        rd_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic wr_status(input logic [15:0] v);
        @(negedge clk);
        reg_sel = 1'b1; wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0; reg_sel = 1'b0; wr_data = '0;
    endtask

    task automatic chk_fill(input int e, input string tag);
        @(negedge clk);
        check(fill_count == 7'(e), tag, fill_count, e);
    endtask

    initial begin
        rst = 1; soft_rst = 0; rx_en = 1; rx_valid = 0; rx_data = 0;
        reg_sel = 0; rd_en = 0; wr_en = 0; wr_data = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk_fill(0, "R1 fill after reset");
        rd_status(16'h0000, "R1 status after reset");
        rd_fifo();                                   // R1/R3 empty data read -> 0

        // R2 ordering
        for (int i = 0; i < 5; i++) rx_char(8'h10 + 8'(i), 1'b1);
        chk_fill(5, "R2 fill after 5 pushes");
        for (int i = 0; i < 3; i++) rd_fifo();
        chk_fill(2, "R2 fill after 3 reads");
        // R3 empty read mid-stream
        for (int i = 0; i < 3; i++) rd_fifo();
        chk_fill(0, "R3 fill after empty read");
        rx_char(8'h5A, 1'b1);
        rd_fifo();                                   // R3 order kept after empty read

        // R8 disabled receiver ignores strobes
        rx_char(8'hEE, 1'b0);
        chk_fill(0, "R8 fill with rx_en=0");

        // Fill exactly to 64
        for (int i = 0; i < 64; i++) rx_char(8'(i * 3 + 1), 1'b1);
        chk_fill(64, "R2 fill at full");

        // R9 push and pop together on full buffer
        @(negedge clk);
        rx_valid = 1; rx_data = 8'hAA; reg_sel = 0; rd_en = 1;
        exp_q.push_back(8'hAA);                      // pop handled by monitor first
        @(posedge clk); #1;
        rx_valid = 0; rd_en = 0;
        chk_fill(64, "R9 fill after push+pop on full");
        rd_status(16'h0000, "R9 no overrun on push+pop");

        // R4 overrun
        rx_char(8'h55, 1'b1);
        chk_fill(64, "R4 fill after overrun");
        rd_status(16'h0001, "R4 flag set");          // arms

        // R7 write 1 disarms, write 0 unarmed has no effect
        wr_status(16'h0001);
        rd_status(16'h0001, "R7 flag kept after writing 1");
        wr_status(16'h0001);                         // disarm again
        wr_status(16'h0000);
        rd_status(16'h0001, "R7 flag kept after unarmed write 0");

        // R5 blocked after freeing space
        rd_fifo(); rd_fifo();
        rx_char(8'h77, 1'b1);
        chk_fill(62, "R5 no store while flag set");

        // R8 flag retained with receiver off
        rx_char(8'h66, 1'b0);
        rd_status(16'h0001, "R8 flag kept with rx_en=0");

        // R6 upper bits
        wr_status(16'hFFFF);
        rd_status(16'h0001, "R6 upper bits read zero, flag kept");

        // R7 proper clear
        wr_status(16'h0000);
        rd_status(16'h0000, "R7 flag cleared by armed write 0");
        m_flag = 0;
        rx_char(8'h99, 1'b1);
        chk_fill(63, "R7 reception resumes");

        // R10 manual reset
        rx_char(8'h9A, 1'b1);
        rx_char(8'h9B, 1'b1);
        rd_status(16'h0001, "R10 flag set before soft reset");
        @(negedge clk); soft_rst = 1;
        @(posedge clk); #1 soft_rst = 0;
        m_flag = 0;
        rd_status(16'h0000, "R10 flag cleared by soft reset");
        chk_fill(64, "R10 contents kept");

        // Drain and verify order
        for (int i = 0; i < 64; i++) rd_fifo();
        chk_fill(0, "R2 drained");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule